// File: doc/BRIEF.md
# Double-Buffered Byte Serializer/Deserializer with Raw-Bit Bypass

This block sits between a host register interface and a single-bit serial line. On the transmit side the host writes bytes into a holding register. A shifter sends the current byte one bit per bit-clock enable, most-significant bit first. While the shifter works, the host can already load the next byte. When the holding register is refilled in time, bytes follow one another with no idle bit between them. On the receive side, incoming bits are collected into a shifter. Every completed byte is copied into a readable data register, a full flag is set, and an interrupt can be raised. If the host has not read a byte when the next one completes, the old byte is overwritten and an overrun flag records the loss.

Receive byte boundaries are counted from reset, one byte every `DATA_W` enables. The transmit engine is a two-state machine. `TX_IDLE` drives the line high. `TX_SHIFT` drives the shifter's top bit. The machine has four transitions:
- `TX_IDLE -> TX_SHIFT`: taken on an enable when the holding register is full.
- `TX_SHIFT -> TX_SHIFT`: a reload, taken on the enable that ends the last bit when the holding register is full.
- `TX_SHIFT -> TX_IDLE`: taken on that same enable when the holding register is empty.
- Otherwise the machine stays in its state.

A bypass input turns off both byte engines and carries raw data bits between the host and the line. The transmit bit is registered onto the line, and the line is sampled into a receive bit, on each enable.

Top module: `bitlink_serdes`

## Requirements
- R1: After reset, `tx_empty`=1, `rx_full`=0, `rx_overrun`=0 and `ser_out`=1. `irq`=0 while both interrupt enables are 0.
- R2: Bits go out most-significant first, one bit per `bit_en`. The first bit of a byte written while the machine is idle appears on `ser_out` right after the next `bit_en` cycle.
- R3: A host write clears `tx_empty` in the following cycle. `tx_empty` sets again only in the cycle after a `bit_en` that moves the holding byte into the shifter.
- R4: If the holding register is full when the last bit of a byte is ended by `bit_en`, the next byte's most-significant bit appears at once, with no idle bit.
- R5: If the holding register is empty at that point, `ser_out` returns to 1 and stays 1. After the next write, sending resumes on the following `bit_en`.
- R6: Receive bits are sampled from `ser_in` on each `bit_en`, most-significant first. Every `DATA_W`-th enable since reset completes a byte. The completed byte is placed on `host_rdata` and sets `rx_full`. `host_rdata` changes only on such an enable.
- R7: A host read pulse (`host_rd`) clears `rx_full` and `rx_overrun`.
- R8: A byte that completes while `rx_full` is still 1 overwrites `host_rdata` and sets `rx_overrun`.
- R9: `irq` = (`tx_empty` AND `irq_tx_en`) OR (`rx_full` AND `irq_rx_en`).
- R10: With `bypass`=1, each `bit_en` copies `byp_tx_bit` to `ser_out` and `ser_in` to `byp_rx_bit`. Host writes do not reach the line, and no receive byte completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_en | input | 1 | One-cycle bit-clock enable |
| bypass | input | 1 | Raw-bit mode select |
| host_wr | input | 1 | Write strobe for the transmit holding register |
| host_wdata | input | DATA_W | Transmit byte |
| host_rd | input | 1 | Read strobe for the receive data register |
| host_rdata | output | DATA_W | Receive data register |
| irq_tx_en | input | 1 | Enables the interrupt on transmit empty |
| irq_rx_en | input | 1 | Enables the interrupt on receive full |
| tx_empty | output | 1 | Holding register can take a byte |
| rx_full | output | 1 | Unread receive byte present |
| rx_overrun | output | 1 | A receive byte was overwritten unread |
| irq | output | 1 | Interrupt request |
| ser_out | output | 1 | Serial line out |
| ser_in | input | 1 | Serial line in |
| byp_tx_bit | input | 1 | Raw bit to send in bypass |
| byp_rx_bit | output | 1 | Raw bit received in bypass |

## Verification
The bench builds the block with the default `DATA_W` of 8. With that width, four transmit and four receive bytes share one enable stream, and the byte boundaries of both directions line up. This brings several cases within reach of a short run: gapless back-to-back transmit, the drop to idle and the restart, and an overwrite with overrun that is caused by one deliberately skipped read. The bypass phase then shows that the raw path follows every enable while both byte engines stay still.

// File: rtl/bitlink_pkg.sv
package bitlink_pkg;
    typedef enum logic [0:0] {
        TX_IDLE  = 1'b0,
        TX_SHIFT = 1'b1
    } tx_state_e;
endpackage

// File: rtl/bitlink_tx.sv
module bitlink_tx
    import bitlink_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output logic              ser_o,
    output logic              empty_o
);
    localparam int CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

    tx_state_e         state_q, state_d;
    logic [DATA_W-1:0] hold_q, shift_q;
    logic              hold_full_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              load;

    // next-state and load decision
    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        unique case (state_q)
            TX_IDLE: begin
                if (step && hold_full_q) begin
                    load    = 1'b1;
                    state_d = TX_SHIFT;
                end
            end
            TX_SHIFT: begin
                if (step && cnt_q == LAST) begin
                    if (hold_full_q) load = 1'b1;
                    else             state_d = TX_IDLE;
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q      <= '0;
            hold_full_q <= 1'b0;
            shift_q     <= '0;
            cnt_q       <= '0;
        end else begin
            hold_full_q <= (hold_full_q & ~load) | wr;
            if (wr) hold_q <= wdata;
            if (load) begin
                shift_q <= hold_q;
                cnt_q   <= '0;
            end else if (state_q == TX_SHIFT && step) begin
                shift_q <= {shift_q[DATA_W-2:0], 1'b0};
                cnt_q   <= CNT_W'(cnt_q + 1'b1);
            end
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            TX_IDLE:  ser_o = 1'b1;
            TX_SHIFT: ser_o = shift_q[DATA_W-1];
        endcase
        empty_o = ~hold_full_q;
    end
endmodule

// File: rtl/bitlink_rx.sv
module bitlink_rx #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              rd,
    input  logic              ser_i,
    output logic [DATA_W-1:0] data_o,
    output logic              full_o,
    output logic              ovr_o
);
    localparam int CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

    logic [DATA_W-1:0] sreg_q, data_q, word;
    logic [CNT_W-1:0]  cnt_q;
    logic              full_q, ovr_q, done;

    assign word = {sreg_q[DATA_W-2:0], ser_i};
    assign done = step && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg_q <= '0;
            data_q <= '0;
            cnt_q  <= '0;
            full_q <= 1'b0;
            ovr_q  <= 1'b0;
        end else begin
            if (step) begin
                sreg_q <= word;
                cnt_q  <= done ? '0 : CNT_W'(cnt_q + 1'b1);
            end
            if (done) begin
                data_q <= word;
                full_q <= 1'b1;
                ovr_q  <= (ovr_q | full_q) & ~rd;
            end else if (rd) begin
                full_q <= 1'b0;
                ovr_q  <= 1'b0;
            end
        end
    end

    assign data_o = data_q;
    assign full_o = full_q;
    assign ovr_o  = ovr_q;
endmodule

// File: rtl/bitlink_bypass.sv
module bitlink_bypass (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    input  logic tx_bit_i,
    input  logic ser_i,
    output logic ser_o,
    output logic rx_bit_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ser_o    <= 1'b1;
            rx_bit_o <= 1'b0;
        end else if (step) begin
            ser_o    <= tx_bit_i;
            rx_bit_o <= ser_i;
        end
    end
endmodule

// File: rtl/bitlink_serdes.sv
module bitlink_serdes #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              bypass,
    input  logic              host_wr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              host_rd,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              irq_tx_en,
    input  logic              irq_rx_en,
    output logic              tx_empty,
    output logic              rx_full,
    output logic              rx_overrun,
    output logic              irq,
    output logic              ser_out,
    input  logic              ser_in,
    input  logic              byp_tx_bit,
    output logic              byp_rx_bit
);
    logic frame_step, raw_step, tx_line, raw_line;

    assign frame_step = bit_en & ~bypass;
    assign raw_step   = bit_en &  bypass;

    bitlink_tx #(.DATA_W(DATA_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .step(frame_step), .wr(host_wr),
        .wdata(host_wdata), .ser_o(tx_line), .empty_o(tx_empty)
    );

    bitlink_rx #(.DATA_W(DATA_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .step(frame_step), .rd(host_rd),
        .ser_i(ser_in), .data_o(host_rdata), .full_o(rx_full), .ovr_o(rx_overrun)
    );

    bitlink_bypass u_byp (
        .clk(clk), .rst_n(rst_n), .step(raw_step), .tx_bit_i(byp_tx_bit),
        .ser_i(ser_in), .ser_o(raw_line), .rx_bit_o(byp_rx_bit)
    );

    assign ser_out = bypass ? raw_line : tx_line;
    assign irq     = (tx_empty & irq_tx_en) | (rx_full & irq_rx_en);
endmodule

// File: rtl/bitlink_serdes_chk.sv
module bitlink_serdes_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bit_en,
    input logic              bypass,
    input logic              host_wr,
    input logic              host_rd,
    input logic [DATA_W-1:0] host_rdata,
    input logic              tx_empty,
    input logic              rx_full,
    input logic              rx_overrun,
    input logic              ser_out
);
    // R3
    wr_clears_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr |=> !tx_empty);
    // R3
    empty_sets_on_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_empty) |-> $past(bit_en));
    // R2
    line_holds_between_enables_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_en && !bypass) |=> (bypass || $stable(ser_out)));
    // R6
    rdata_holds_between_enables_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(host_rdata));
    // R7
    read_clears_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !(bit_en && !bypass)) |=> (!rx_full && !rx_overrun));
    // R8
    overrun_implies_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_overrun) |-> rx_full);
endmodule

bind bitlink_serdes bitlink_serdes_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bypass(bypass),
    .host_wr(host_wr), .host_rd(host_rd), .host_rdata(host_rdata),
    .tx_empty(tx_empty), .rx_full(rx_full), .rx_overrun(rx_overrun),
    .ser_out(ser_out)
);

// File: tb/bitlink_serdes_tb.sv
module bitlink_serdes_tb;
    localparam int W = 8;
    localparam int N = 4;
    // {tx byte, rx byte, read after completion}
    localparam logic [2*W:0] VEC [N] = '{
        {8'hA5, 8'hC3, 1'b1},
        {8'h3C, 8'h5A, 1'b0},
        {8'hFF, 8'h81, 1'b1},
        {8'h02, 8'h7E, 1'b1}
    };

    logic clk = 0, rst_n = 0;
    logic bit_en = 0, bypass = 0, host_wr = 0, host_rd = 0;
    logic [W-1:0] host_wdata = '0, host_rdata;
    logic irq_tx_en = 0, irq_rx_en = 0;
    logic tx_empty, rx_full, rx_overrun, irq, ser_out;
    logic ser_in = 0, byp_tx_bit = 0, byp_rx_bit;
    int checks = 0, failures = 0;
    logic unread;

    always #5 clk = ~clk;

    bitlink_serdes #(.DATA_W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bypass(bypass),
        .host_wr(host_wr), .host_wdata(host_wdata), .host_rd(host_rd),
        .host_rdata(host_rdata), .irq_tx_en(irq_tx_en), .irq_rx_en(irq_rx_en),
        .tx_empty(tx_empty), .rx_full(rx_full), .rx_overrun(rx_overrun),
        .irq(irq), .ser_out(ser_out), .ser_in(ser_in),
        .byp_tx_bit(byp_tx_bit), .byp_rx_bit(byp_rx_bit)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk) bit_en = 1;
        @(negedge clk) bit_en = 0;
    endtask

    task automatic write(input logic [W-1:0] d);
        @(negedge clk) begin host_wr = 1; host_wdata = d; end
        @(negedge clk) host_wr = 0;
    endtask

    task automatic read();
        @(negedge clk) host_rd = 1;
        @(negedge clk) host_rd = 0;
    endtask

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R1 tx_empty", tx_empty, 1);
        check("R1 rx_full", rx_full, 0);
        check("R1 rx_overrun", rx_overrun, 0);
        check("R1 ser_out", ser_out, 1);
        check("R1 irq", irq, 0);
        irq_tx_en = 1;
        @(negedge clk);
        check("R9 irq on tx_empty", irq, 1);
        irq_tx_en = 0;
        irq_rx_en = 1;

        write(VEC[0][2*W:W+1]);
        check("R3 empty cleared by write", tx_empty, 0);
        check("R2 line idle before enable", ser_out, 1);
        unread = 0;
        for (int i = 0; i < N; i++) begin
            for (int b = W - 1; b >= 0; b--) begin
                ser_in = VEC[i][W + b - W + 1 + 0 - 0 + b - b];
                ser_in = VEC[i][1 + b];
                tick();
                if (i > 0 && b == W - 1)
                    check("R4 gapless next msb", ser_out, VEC[i][W + 1 + b]);
                else
                    check("R2 tx bit", ser_out, VEC[i][W + 1 + b]);
                if (b == W - 1) begin
                    check("R3 empty after load", tx_empty, 1);
                    if (i < N - 1) write(VEC[i+1][2*W:W+1]);
                end
            end
            check("R6 rx_full", rx_full, 1);
            check("R6 rdata", host_rdata, VEC[i][W:1]);
            check("R8 overrun", rx_overrun, unread);
            check("R9 irq on rx_full", irq, 1);
            if (VEC[i][0]) begin
                read();
                check("R7 full cleared", rx_full, 0);
                check("R7 overrun cleared", rx_overrun, 0);
                check("R9 irq after read", irq, 0);
                unread = 0;
            end else begin
                unread = 1;
            end
        end

        ser_in = 0;
        tick();
        check("R5 idle after underrun", ser_out, 1);
        tick();
        check("R5 stays idle", ser_out, 1);
        write(8'h40);
        check("R5 no bit before enable", ser_out, 1);
        tick();
        check("R5 resume msb", ser_out, 0);
        tick();
        check("R5 resume bit6", ser_out, 1);
        for (int k = 0; k < W - 2; k++) tick();
        read();

        bypass = 1;
        byp_tx_bit = 0;
        ser_in = 0;
        tick();
        check("R10 raw tx 0", ser_out, 0);
        check("R10 raw rx 0", byp_rx_bit, 0);
        byp_tx_bit = 1;
        ser_in = 1;
        tick();
        check("R10 raw tx 1", ser_out, 1);
        check("R10 raw rx 1", byp_rx_bit, 1);
        byp_tx_bit = 0;
        write(8'hFF);
        for (int k = 0; k < W; k++) tick();
        check("R10 write not on line", ser_out, 0);
        check("R10 no rx byte in bypass", rx_full, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule